// File: doc/BRIEF.md
# Doorbell Peer Notification Dispatcher

This block turns 32-bit doorbell words into notifications for a destination peer. It takes the destination peer index from the upper half of the word and the vector number from the low byte. It checks both against a table that holds one registered-vector count per peer. When the request is valid, it raises a one-cycle notify pulse carrying the peer and the vector. When the request is not valid, it raises a drop flag instead.

The table is maintained through two further ports. A registration adds one vector to a peer. The new vector's index is the peer's count before the registration, and the count then grows by one. A departure clears every vector of a peer at once. The number of peers and the maximum number of vectors per peer are fixed parameters. All outputs are registered and appear one clock after the request that caused them.

Top module: `doorbell_dispatch`

## Requirements
- R1: A doorbell takes its destination peer from word bits 31:16 and its vector from bits 7:0; bits 15:8 have no effect. An accepted doorbell gives, one cycle later, `notifyPulse`=1 for exactly one cycle with `notifyPeer` and `notifyVector` equal to the decoded fields, and `dbDrop`=0.
- R2: A doorbell whose destination is greater than or equal to NUM_PEERS gives `dbDrop`=1 and `notifyPulse`=0 one cycle later.
- R3: A doorbell whose vector is greater than or equal to the destination's current count gives `dbDrop`=1 and no notify. A peer with count 0 accepts no doorbell.
- R4: An accepted registration gives, one cycle later, `regAck`=1 with `regIndex` equal to the peer's count before the registration, and that count then grows by one.
- R5: A registration to a peer whose count already equals MAX_VECTORS gives `regError`=1 and `regAck`=0, and leaves the count unchanged.
- R6: A registration naming a peer greater than or equal to NUM_PEERS gives `regError`=1 and changes no count.
- R7: A departure for a valid peer sets that peer's count to zero, so later doorbells to it are dropped and its next registration gets index 0. `leaveError` stays 0.
- R8: A departure naming a peer greater than or equal to NUM_PEERS gives `leaveError`=1 one cycle later and changes no count.
- R9: A doorbell that arrives in the same cycle as a registration or a departure is judged against the counts from before that cycle's update.
- R10: When a registration and a valid departure name the same peer in one cycle, the departure wins. The registration gives `regError`=1 and the count ends at zero.
- R11: After reset every count is zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dbValid | input | 1 | Doorbell word present this cycle |
| dbWord | input | 32 | Doorbell word: peer in 31:16, vector in 7:0 |
| regValid | input | 1 | Registration request present |
| regPeer | input | 16 | Peer gaining one vector |
| leaveValid | input | 1 | Departure notice present |
| leavePeer | input | 16 | Peer whose vectors are all removed |
| notifyPulse | output | 1 | One-cycle notify for an accepted doorbell |
| notifyPeer | output | 16 | Destination peer of the notify |
| notifyVector | output | 8 | Vector of the notify |
| dbDrop | output | 1 | Doorbell was rejected |
| regAck | output | 1 | Registration accepted |
| regIndex | output | 8 | Vector index assigned by the registration |
| regError | output | 1 | Registration rejected |
| leaveError | output | 1 | Departure named an out-of-range peer |

## Verification
A doorbell can land in the same cycle as a registration or a departure for the same peer. In that case the doorbell must see the count from before the update. The bench drives a doorbell to the vector index the registration is about to create, which must be dropped. It then drives a doorbell to a live vector alongside a departure of that peer, which must still notify. A registration and a departure for one peer can also coincide. The bench provokes this and expects a registration error. It then confirms through a doorbell and a fresh registration that the count ended at zero.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int PEER_W = 16;
  localparam int VEC_W  = 8;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic              incEn;
    logic [PEER_W-1:0] incPeer;
    logic              clrEn;
    logic [PEER_W-1:0] clrPeer;
  } tableStrobes_t;
endpackage

// File: rtl/doorbell_table.sv
module doorbell_table
  import doorbell_pkg::*;
#(
  parameter int NUM_PEERS   = 16,
  parameter int MAX_VECTORS = 8,
  localparam int CNT_W = $clog2(MAX_VECTORS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  tableStrobes_t        strb,
  input  logic [PEER_W-1:0]    dbPeer,
  input  logic [PEER_W-1:0]    regPeer,
  output logic [CNT_W-1:0]     dbCount,
  output logic [CNT_W-1:0]     regCount
);
  logic [CNT_W-1:0] cnt [NUM_PEERS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PEERS; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_PEERS; i++) begin
        if (strb.clrEn && strb.clrPeer == PEER_W'(i))
          cnt[i] <= '0;
        else if (strb.incEn && strb.incPeer == PEER_W'(i))
          cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  always_comb begin
    dbCount  = '0;
    regCount = '0;
    for (int i = 0; i < NUM_PEERS; i++) begin
      if (dbPeer == PEER_W'(i))  dbCount  = cnt[i];
      if (regPeer == PEER_W'(i)) regCount = cnt[i];
    end
  end

  for (genvar g = 0; g < NUM_PEERS; g++) begin : gChk
    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt[g]) <= MAX_VECTORS) else $error("count over limit"); // R5
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.clrEn && strb.clrPeer == PEER_W'(g)) |=> (cnt[g] == '0)) else $error("clear missed"); // R7
  end
endmodule

// File: rtl/doorbell_ctrl.sv
module doorbell_ctrl
  import doorbell_pkg::*;
#(
  parameter int NUM_PEERS   = 16,
  parameter int MAX_VECTORS = 8,
  localparam int CNT_W = $clog2(MAX_VECTORS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dbValid,
  input  logic [WORD_W-1:0]    dbWord,
  input  logic                 regValid,
  input  logic [PEER_W-1:0]    regPeer,
  input  logic                 leaveValid,
  input  logic [PEER_W-1:0]    leavePeer,
  input  logic [CNT_W-1:0]     dbCount,
  input  logic [CNT_W-1:0]     regCount,
  output logic [PEER_W-1:0]    dbPeer,
  output tableStrobes_t        strb,
  output logic                 notifyPulse,
  output logic [PEER_W-1:0]    notifyPeer,
  output logic [VEC_W-1:0]     notifyVector,
  output logic                 dbDrop,
  output logic                 regAck,
  output logic [VEC_W-1:0]     regIndex,
  output logic                 regError,
  output logic                 leaveError
);
  logic [VEC_W-1:0] dbVec;
  logic dbPeerOk, dbHit, regPeerOk, regFull, leavePeerOk, regClash, regAccept;

  assign dbPeer      = dbWord[31:16];
  assign dbVec       = dbWord[7:0];
  assign dbPeerOk    = 32'(dbPeer) < NUM_PEERS;
  assign dbHit       = dbPeerOk && (32'(dbVec) < 32'(dbCount));
  assign regPeerOk   = 32'(regPeer) < NUM_PEERS;
  assign regFull     = 32'(regCount) >= MAX_VECTORS;
  assign leavePeerOk = 32'(leavePeer) < NUM_PEERS;
  assign regClash    = leaveValid && leavePeerOk && (leavePeer == regPeer);
  assign regAccept   = regValid && regPeerOk && !regFull && !regClash;

  always_comb begin
    strb.incEn   = regAccept;
    strb.incPeer = regPeer;
    strb.clrEn   = leaveValid && leavePeerOk;
    strb.clrPeer = leavePeer;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notifyPulse  <= 1'b0;
      notifyPeer   <= '0;
      notifyVector <= '0;
      dbDrop       <= 1'b0;
      regAck       <= 1'b0;
      regIndex     <= '0;
      regError     <= 1'b0;
      leaveError   <= 1'b0;
    end else begin
      notifyPulse <= dbValid && dbHit;
      dbDrop      <= dbValid && !dbHit;
      if (dbValid && dbHit) begin
        notifyPeer   <= dbPeer;
        notifyVector <= dbVec;
      end
      regAck     <= regAccept;
      regError   <= regValid && !regAccept;
      if (regAccept) regIndex <= VEC_W'(regCount);
      leaveError <= leaveValid && !leavePeerOk;
    end
  end

  AST_NOTIFY_NEEDS_DB: assert property (@(posedge clk) disable iff (!rst_n)
    notifyPulse |-> $past(dbValid)) else $error("notify without doorbell"); // R1
  AST_NOTIFY_PEER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    notifyPulse |-> (32'(notifyPeer) < NUM_PEERS)) else $error("notify peer out of range"); // R2
  AST_DB_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(notifyPulse && dbDrop)) else $error("notify and drop together"); // R3
  AST_REG_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(regAck && regError)) else $error("ack and error together"); // R4
  AST_ACK_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    regAck |-> (32'(regIndex) < MAX_VECTORS)) else $error("index beyond limit"); // R5
  AST_LEAVE_ERR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    leaveError |-> $past(leaveValid)) else $error("leave error without notice"); // R8
endmodule

// File: rtl/doorbell_dispatch.sv
module doorbell_dispatch
  import doorbell_pkg::*;
#(
  parameter int NUM_PEERS   = 16,
  parameter int MAX_VECTORS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dbValid,
  input  logic [31:0] dbWord,
  input  logic        regValid,
  input  logic [15:0] regPeer,
  input  logic        leaveValid,
  input  logic [15:0] leavePeer,
  output logic        notifyPulse,
  output logic [15:0] notifyPeer,
  output logic [7:0]  notifyVector,
  output logic        dbDrop,
  output logic        regAck,
  output logic [7:0]  regIndex,
  output logic        regError,
  output logic        leaveError
);
  localparam int CNT_W = $clog2(MAX_VECTORS + 1);

  tableStrobes_t      strb;
  logic [PEER_W-1:0]  dbPeer;
  logic [CNT_W-1:0]   dbCount, regCount;

  doorbell_ctrl #(.NUM_PEERS(NUM_PEERS), .MAX_VECTORS(MAX_VECTORS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .dbValid(dbValid), .dbWord(dbWord),
    .regValid(regValid), .regPeer(regPeer),
    .leaveValid(leaveValid), .leavePeer(leavePeer),
    .dbCount(dbCount), .regCount(regCount),
    .dbPeer(dbPeer), .strb(strb),
    .notifyPulse(notifyPulse), .notifyPeer(notifyPeer), .notifyVector(notifyVector),
    .dbDrop(dbDrop), .regAck(regAck), .regIndex(regIndex),
    .regError(regError), .leaveError(leaveError)
  );

  doorbell_table #(.NUM_PEERS(NUM_PEERS), .MAX_VECTORS(MAX_VECTORS)) u_table (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .dbPeer(dbPeer), .regPeer(regPeer),
    .dbCount(dbCount), .regCount(regCount)
  );
endmodule

// File: tb/doorbell_dispatch_tb.sv
module doorbell_dispatch_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic dbValid = 0, regValid = 0, leaveValid = 0;
  logic [31:0] dbWord = '0;
  logic [15:0] regPeer = '0, leavePeer = '0;
  logic notifyPulse, dbDrop, regAck, regError, leaveError;
  logic [15:0] notifyPeer;
  logic [7:0] notifyVector, regIndex;
  int testsRun = 0, testsFailed = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  doorbell_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .dbValid(dbValid), .dbWord(dbWord),
    .regValid(regValid), .regPeer(regPeer), .leaveValid(leaveValid), .leavePeer(leavePeer),
    .notifyPulse(notifyPulse), .notifyPeer(notifyPeer), .notifyVector(notifyVector),
    .dbDrop(dbDrop), .regAck(regAck), .regIndex(regIndex),
    .regError(regError), .leaveError(leaveError)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Called at a negedge: drive, wait one cycle, release inputs.
  task automatic cycle(bit dv, logic [31:0] w, bit rv, logic [15:0] rp, bit lv, logic [15:0] lp);
    dbValid = dv; dbWord = w; regValid = rv; regPeer = rp; leaveValid = lv; leavePeer = lp;
    @(negedge clk);
    dbValid = 0; regValid = 0; leaveValid = 0;
  endtask

  function automatic logic [31:0] word(logic [15:0] p, logic [7:0] junk, logic [7:0] v);
    return {p, junk, v};
  endfunction

  task automatic doorbell(string tag, logic [15:0] p, logic [7:0] v, bit expHit);
    cycle(1, word(p, 8'h5A, v), 0, 0, 0, 0);
    chk({tag, " notify"}, notifyPulse, expHit);
    chk({tag, " drop"}, dbDrop, !expHit);
    if (expHit) begin
      chk({tag, " peer"}, notifyPeer, p);
      chk({tag, " vector"}, notifyVector, v);
    end
  endtask

  task automatic register(string tag, logic [15:0] p, bit expOk, logic [7:0] expIdx);
    cycle(0, 0, 1, p, 0, 0);
    chk({tag, " ack"}, regAck, expOk);
    chk({tag, " err"}, regError, !expOk);
    if (expOk) chk({tag, " index"}, regIndex, expIdx);
  endtask

  task automatic t_reset;
    chk("R11 notify low", notifyPulse, 0);
    chk("R11 drop low", dbDrop, 0);
    chk("R11 ack low", regAck, 0);
    chk("R11 errors low", {regError, leaveError}, 0);
    doorbell("R11 empty table", 0, 0, 0);
  endtask

  task automatic t_register;
    register("R4 first", 3, 1, 0);
    register("R4 second", 3, 1, 1);
    register("R4 third", 3, 1, 2);
    doorbell("R1 top vector", 3, 2, 1);
    cycle(1, word(3, 8'hFF, 0), 0, 0, 0, 0);
    chk("R1 middle bits ignored", notifyPulse, 1);
    chk("R1 notify vector", notifyVector, 0);
    chk("R1 single cycle pulse", notifyPulse, 1);
    @(negedge clk);
    chk("R1 pulse ended", notifyPulse, 0);
    doorbell("R3 vector at count", 3, 3, 0);
    doorbell("R3 vector far above", 3, 8'hFF, 0);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 8; i++) register("R4 fill", 5, 1, 8'(i));
    register("R5 beyond limit", 5, 0, 0);
    doorbell("R5 last vector", 5, 7, 1);
    doorbell("R5 count unchanged", 5, 8, 0);
  endtask

  task automatic t_badpeer;
    doorbell("R2 peer at bound", 16, 0, 0);
    doorbell("R2 peer max", 16'hFFFF, 0, 0);
    register("R6 peer out of range", 20, 0, 0);
    doorbell("R6 no aliasing", 4, 0, 0);
  endtask

  task automatic t_leave;
    cycle(0, 0, 0, 0, 1, 3);
    chk("R7 no leave error", leaveError, 0);
    doorbell("R7 after departure", 3, 0, 0);
    register("R7 restarts at zero", 3, 1, 0);
    cycle(0, 0, 0, 0, 1, 21);
    chk("R8 leave error", leaveError, 1);
    doorbell("R8 alias peer intact", 5, 7, 1);
  endtask

  task automatic t_same_cycle;
    // peer 3 holds count 1
    cycle(1, word(3, 0, 1), 1, 3, 0, 0);
    chk("R9 db before reg drop", dbDrop, 1);
    chk("R9 db before reg notify", notifyPulse, 0);
    chk("R9 reg ack", regAck, 1);
    chk("R9 reg index", regIndex, 1);
    cycle(1, word(3, 0, 1), 0, 0, 1, 3);
    chk("R9 db with leave notify", notifyPulse, 1);
    chk("R9 db with leave vector", notifyVector, 1);
    doorbell("R9 leave took effect", 3, 0, 0);
  endtask

  task automatic t_reg_leave;
    register("R10 setup", 6, 1, 0);
    cycle(0, 0, 1, 6, 1, 6);
    chk("R10 reg rejected", regError, 1);
    chk("R10 no ack", regAck, 0);
    chk("R10 no leave error", leaveError, 0);
    doorbell("R10 count zero", 6, 0, 0);
    register("R10 fresh index", 6, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_register;
    t_saturate;
    t_badpeer;
    t_leave;
    t_same_cycle;
    t_reg_leave;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule